// File: doc/BRIEF.md
# Handshaked Composite-Field Byte Substitution Stage

This block is one pipeline stage that applies the AES forward byte substitution to a single byte on each transfer. It stores no 256-entry table. The byte is carried by a linear change of basis into a two-level field: a degree-two extension over GF(2^4). In that field it is inverted with four-bit multipliers, squarers and a four-bit inverter. A second linear map brings the result back, and the AES affine step with constant 0x63 is folded into that same map.

Both sides of the stage use a four-phase request/acknowledge protocol. The sequence is: request rises, acknowledge rises, request falls, acknowledge falls. A synchronous controller lets the stage register load only when the upstream side offers a fresh request and the downstream side has fully finished the previous transfer. Nothing else enables the register. A sender holds `in_data` steady from the rise of `in_req` until it sees `in_ack` rise. A receiver reads `out_data` while `out_req` is high.

Top module: `aes_cf_sbox_stage`

## Requirements
- R1: For every input byte, the byte presented on `out_data` for that transfer equals the AES forward substitution of the input: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine step b ^ rotl1(b) ^ rotl2(b) ^ rotl3(b) ^ rotl4(b) ^ 0x63.
- R2: Input 0x00 yields 0x63, because zero is its own inverse.
- R3: `in_ack` rises only on a clock edge where `in_req` is high, and it stays high as long as `in_req` stays high.
- R4: Once `in_req` is low while `in_ack` is high, `in_ack` falls on the next clock edge.
- R5: `out_req` stays high until `out_ack` is seen high, and it falls on the clock edge after `out_ack` is seen high.
- R6: `out_data` does not change while `out_req` is high.
- R7: A new input is not accepted while the stage holds an unfinished output. An output is unfinished while `out_req` or `out_ack` is high. Acceptance shows as a rise of `in_ack` together with a rise of `out_req`.
- R8: After reset, `in_ack` and `out_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronous controller |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_req | input | 1 | Upstream request, four-phase |
| in_data | input | 8 | Byte to substitute, held stable until `in_ack` rises |
| in_ack | output | 1 | Upstream acknowledge |
| out_req | output | 1 | Downstream request, four-phase |
| out_ack | input | 1 | Downstream acknowledge |
| out_data | output | 8 | Substituted byte, valid while `out_req` is high |

## Verification
The hardest condition to reach from the ports is a new upstream request that arrives while the previous result is still waiting on a slow receiver. In that case the stage must hold off its acknowledge until the downstream return-to-zero has completed. The stimulus creates this by running the receiver with an acknowledge delay that varies per transfer, so the sender is usually already waiting. The bench records the receiver's signals in the cycle before each acknowledge appears. Walking all 256 byte values through this back-pressured flow covers zero and every nonzero inverse, with zero checked on its own.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int MAT_W  = BYTE_W * BYTE_W;
  localparam logic [NIB_W-1:0]  NIB_POLY = 4'h3;   // x^4 + x + 1
  localparam logic [BYTE_W-1:0] AFF_C    = 8'h63;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [MAT_W-1:0]  mat_t;

  function automatic nib_t gf4_mul(nib_t a, nib_t b);
    nib_t r = '0;
    nib_t t = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) r = r ^ t;
      t = t[NIB_W-1] ? ({t[NIB_W-2:0], 1'b0} ^ NIB_POLY) : {t[NIB_W-2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic nib_t gf4_sq(nib_t a);
    return gf4_mul(a, a);
  endfunction

  // a^-1 = a^14 = a^8 * a^4 * a^2 ; zero maps to zero
  function automatic nib_t gf4_inv(nib_t a);
    nib_t a2 = gf4_sq(a);
    nib_t a4 = gf4_sq(a2);
    nib_t a8 = gf4_sq(a4);
    return gf4_mul(gf4_mul(a8, a4), a2);
  endfunction

  // element = hi*y + lo, with y^2 = y + lam
  function automatic byte_t cf_mul(byte_t a, byte_t b, nib_t lam);
    nib_t hh = gf4_mul(a[7:4], b[7:4]);
    nib_t hi = hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]);
    nib_t lo = gf4_mul(hh, lam) ^ gf4_mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic nib_t cf_norm(byte_t a, nib_t lam);
    return gf4_mul(gf4_sq(a[7:4]), lam) ^ gf4_mul(a[7:4], a[3:0]) ^ gf4_sq(a[3:0]);
  endfunction

  function automatic byte_t cf_inv(byte_t a, nib_t lam);
    nib_t di = gf4_inv(cf_norm(a, lam));
    return {gf4_mul(a[7:4], di), gf4_mul(a[7:4] ^ a[3:0], di)};
  endfunction

  // first lam for which y^2 + y + lam has no root in GF(2^4)
  function automatic nib_t find_lambda();
    for (int l = 1; l < 16; l++) begin
      bit hit = 1'b0;
      for (int y = 0; y < 16; y++)
        if ((gf4_sq(nib_t'(y)) ^ nib_t'(y)) == nib_t'(l)) hit = 1'b1;
      if (!hit) return nib_t'(l);
    end
    return nib_t'(0);
  endfunction

  // a composite-field root of x^8 + x^4 + x^3 + x + 1
  function automatic byte_t find_root(nib_t lam);
    for (int c = 2; c < 256; c++) begin
      byte_t p = byte_t'(1);
      byte_t acc = byte_t'(1);
      for (int e = 1; e <= 8; e++) begin
        p = cf_mul(p, byte_t'(c), lam);
        if (e == 1 || e == 3 || e == 4 || e == 8) acc = acc ^ p;
      end
      if (acc == '0) return byte_t'(c);
    end
    return '0;
  endfunction

  function automatic byte_t mat_apply(mat_t m, byte_t v);
    byte_t r = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (v[i]) r = r ^ m[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic byte_t mat_row(mat_t m, int k);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++) r[i] = m[i*BYTE_W + k];
    return r;
  endfunction

  function automatic byte_t rotl(byte_t b, int n);
    byte_t r = (b << n) | (b >> (BYTE_W - n));
    return r;
  endfunction

  function automatic byte_t aff_lin(byte_t b);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4);
  endfunction

  // column i is root^i : standard basis -> composite basis
  function automatic mat_t build_fwd(byte_t root, nib_t lam);
    mat_t m = '0;
    byte_t p = byte_t'(1);
    for (int i = 0; i < BYTE_W; i++) begin
      m[i*BYTE_W +: BYTE_W] = p;
      p = cf_mul(p, root, lam);
    end
    return m;
  endfunction

  // inverse of the forward map, followed by the linear part of the affine step
  function automatic mat_t build_back(mat_t fwd);
    mat_t m = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      byte_t col = '0;
      for (int a = 0; a < 256; a++)
        if (mat_apply(fwd, byte_t'(a)) == byte_t'(1 << j)) col = byte_t'(a);
      m[j*BYTE_W +: BYTE_W] = aff_lin(col);
    end
    return m;
  endfunction
endpackage

// File: rtl/cf_lin_map.sv
module cf_lin_map
  import aes_cf_pkg::*;
#(
  parameter mat_t  MAT    = '0,
  parameter byte_t OFFSET = '0
) (
  input  byte_t din,
  output byte_t dout
);
  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    localparam byte_t ROW = mat_row(MAT, k);
    assign dout[k] = (^(din & ROW)) ^ OFFSET[k];
  end
endmodule

// File: rtl/cf_inverter.sv
module cf_inverter
  import aes_cf_pkg::*;
#(
  parameter nib_t LAM = 4'h8
) (
  input  byte_t a,
  output byte_t a_inv
);
  nib_t norm;
  nib_t norm_inv;
  assign norm     = cf_norm(a, LAM);
  assign norm_inv = gf4_inv(norm);
  assign a_inv    = {gf4_mul(a[7:4], norm_inv), gf4_mul(a[7:4] ^ a[3:0], norm_inv)};
endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic out_ack,
  output logic in_ack,
  output logic out_req,
  output logic load
);
  logic full;

  assign load = in_req & ~in_ack & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ack  <= 1'b0;
      out_req <= 1'b0;
      full    <= 1'b0;
    end else begin
      if (load) begin
        in_ack  <= 1'b1;
        out_req <= 1'b1;
        full    <= 1'b1;
      end else begin
        if (in_ack && !in_req) in_ack <= 1'b0;
        if (out_req && out_ack) out_req <= 1'b0;
        if (full && !out_req && !out_ack) full <= 1'b0;
      end
    end
  end

  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && in_req |=> in_ack);
  p_ack_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_req |=> !$rose(in_ack));
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !in_req |=> !in_ack);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req);
  p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && out_ack |=> !out_req);
  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req || out_ack) |=> !$rose(in_ack));
endmodule

// File: rtl/aes_cf_sbox_stage.sv
module aes_cf_sbox_stage
  import aes_cf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_req,
  input  logic [7:0]  in_data,
  output logic        in_ack,
  output logic        out_req,
  input  logic        out_ack,
  output logic [7:0]  out_data
);
  localparam nib_t  LAM  = find_lambda();
  localparam byte_t ROOT = find_root(LAM);
  localparam mat_t  FWD  = build_fwd(ROOT, LAM);
  localparam mat_t  BACK = build_back(FWD);

  byte_t fld_in;
  byte_t fld_inv;
  byte_t sub_byte;
  byte_t data_q;
  logic  load;

  cf_lin_map #(.MAT(FWD), .OFFSET('0)) i_to_field (
    .din (in_data),
    .dout(fld_in)
  );

  cf_inverter #(.LAM(LAM)) i_inv (
    .a    (fld_in),
    .a_inv(fld_inv)
  );

  cf_lin_map #(.MAT(BACK), .OFFSET(AFF_C)) i_from_field (
    .din (fld_inv),
    .dout(sub_byte)
  );

  hs_stage_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_req (in_req),
    .out_ack(out_ack),
    .in_ack (in_ack),
    .out_req(out_req),
    .load   (load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= sub_byte;
  end

  assign out_data = data_q;

  p_field_inverse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load && fld_in != '0 |-> cf_mul(fld_in, fld_inv, LAM) == byte_t'(1));
  p_zero_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_data == '0 |=> out_data == AFF_C);
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> $stable(out_data));
endmodule

// File: tb/test_aes_cf_sbox_stage.sv
module test_aes_cf_sbox_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_req = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ack;
  logic       out_req;
  logic       out_ack = 1'b0;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  int received = 0;
  bit driver_done = 1'b0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  aes_cf_sbox_stage i_aes_cf_sbox_stage (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = t[7] ? ((t << 1) ^ 8'h1b) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] x);
    logic [7:0] v = 8'h01;
    logic [7:0] s;
    for (int i = 0; i < 254; i++) v = ref_mul(v, x);
    if (x == 8'h00) v = 8'h00;
    s = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    return s;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // driver: sampling and driving at negedge + 1
  initial begin
    logic p_req;
    logic p_ack;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ack == 1'b0 && out_req == 1'b0, "R8", {6'd0, in_ack, out_req}, 8'h00);
    for (int n = 0; n < 256; n++) begin
      logic [7:0] v = 8'(n ^ 8'h5a);
      in_data = v;
      exp_q.push_back({v, ref_sbox(v)});
      in_req = 1'b1;
      p_req = out_req;
      p_ack = out_ack;
      @(negedge clk); #1;
      while (!in_ack) begin
        p_req = out_req;
        p_ack = out_ack;
        @(negedge clk); #1;
      end
      check(p_req == 1'b0 && p_ack == 1'b0, "R7", {6'd0, p_req, p_ack}, 8'h00);
      if (n % 32 == 0) begin
        repeat (2) begin
          @(negedge clk); #1;
          check(in_ack == 1'b1, "R3", {7'd0, in_ack}, 8'h01);
        end
      end
      in_req = 1'b0;
      in_data = ~v;
      @(negedge clk); #1;
      check(in_ack == 1'b0, "R4", {7'd0, in_ack}, 8'h00);
    end
    driver_done = 1'b1;
  end

  // monitor / scoreboard: drives out_ack at negedge
  initial begin
    logic [15:0] item;
    logic [7:0]  held;
    @(posedge rst_n);
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      while (!out_req) @(negedge clk);
      item = exp_q.pop_front();
      held = out_data;
      check(out_data == item[7:0], "R1", out_data, item[7:0]);
      if (item[15:8] == 8'h00) check(out_data == 8'h63, "R2", out_data, 8'h63);
      for (int d = 0; d < (k % 5) + 1; d++) begin
        @(negedge clk);
        check(out_req == 1'b1, "R5", {7'd0, out_req}, 8'h01);
        check(out_data == held, "R6", out_data, held);
      end
      out_ack = 1'b1;
      @(negedge clk);
      check(out_req == 1'b0, "R5", {7'd0, out_req}, 8'h00);
      repeat (k % 3) @(negedge clk);
      out_ack = 1'b0;
      received++;
    end
  end

  initial begin
    wait (driver_done && received == 256);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired received=%0d expected=256", received);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule